// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block drives program and erase operations on a modelled flash array. The array is a register array of half-word cells. It is split into equal user pages plus a small information block that no operation can change. Software gives commands through a narrow configuration port:

- a control word, which holds the program-enable, page-erase, mass-erase, start and lock bits;
- an address word, which selects the page for a page erase;
- a per-page protection mask;
- a status word whose flags are cleared by writing 1.

Data moves through a separate array port that reads and writes half-words.

A program operation begins with a half-word write to a user cell while program-enable is set. The sequencer first reads the target cell. It drops the write if the page is protected or if the cell is not erased. The one exception is that a write of zero is always allowed. Page erase and mass erase begin from a control write that carries the start bit.

While an operation runs, the busy flag is high. During that time the sequencer ignores configuration writes and stalls every array access until the operation ends. A lock bit and an external unlock pulse gate all configuration changes.

Top module: `flash_seq_top`

## Requirements
- R1: After reset, busy, end-of-operation, program-error and protection-error all read 0 and the block is locked. Every user cell reads 0xFFFF. Information cell k reads 0xC000 + k.
- R2: A program starts on an accepted array write when all of these hold: program-enable (control bit 0) is set, the block is unlocked and idle, the size code is 01 (half-word) and the index lies in the user region. Busy reads 1 from the next cycle and stays high for PROG_LAT+1 cycles. Then the cell holds the written data and end-of-operation (status bit 5) is set.
- R3: An array write that does not start a program raises bus_err_o for one cycle, in the cycle after it is accepted. Such writes include a size code of 00 (byte) or 10 (word), program-enable clear, or an index outside the user region. The write starts no operation and changes no cell.
- R4: A non-zero program to a cell that does not read 0xFFFF is dropped. Busy is high for exactly 1 cycle, program-error (status bit 2) is set and end-of-operation stays 0.
- R5: A program of 0x0000 to a cell that is not erased is carried out: the cell becomes 0x0000, end-of-operation is set and program-error stays 0.
- R6: A program to a page whose mask bit is 1 is dropped, with busy high for 1 cycle. A page erase of such a page is dropped in the same way. In both cases protection-error (status bit 4) is set. Mask bit p guards the cells p*PAGE_WORDS to p*PAGE_WORDS+PAGE_WORDS-1.
- R7: A control write with start (bit 6) and page-erase (bit 1) in the same word erases the page that holds the cell index in the address word. Busy is high for ERASE_LAT+1 cycles and other pages keep their data. A start with neither erase bit starts nothing.
- R8: A control write with start and mass-erase (bit 2) sets every user cell to 0xFFFF, whatever the mask. The information block is left unchanged.
- R9: Writing 1 to a status bit clears that flag. Writing 0 leaves it as it is.
- R10: While busy, arr_ready_o is 0 and configuration writes have no effect. An array read held pending during an operation completes afterwards and returns the data as it stands after the operation.
- R11: While locked, control, address and mask writes are ignored. A pulse on unlock_i unlocks the block. A control write with bit 7 set locks it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unlock_i | input | 1 | One-cycle pulse that opens configuration access |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Register select: 0 control, 1 address, 2 status, 3 mask |
| cfg_wdata_i | input | 32 | Configuration write data |
| arr_req_i | input | 1 | Array access request, held until accepted |
| arr_we_i | input | 1 | Array access is a write |
| arr_size_i | input | 2 | Write size code: 00 byte, 01 half-word, 10 word |
| arr_idx_i | input | AW | Half-word cell index |
| arr_wdata_i | input | 16 | Write data |
| arr_ready_o | output | 1 | Access is accepted on the next edge when high |
| arr_rvalid_o | output | 1 | Read data valid, one cycle after acceptance |
| arr_rdata_o | output | 16 | Read data |
| bus_err_o | output | 1 | Rejected array write, one cycle after acceptance |
| busy_o | output | 1 | Operation in progress |
| eop_o | output | 1 | Operation completed successfully |
| pgerr_o | output | 1 | Program dropped: target not erased |
| wrprterr_o | output | 1 | Operation dropped: page protected |
| locked_o | output | 1 | Configuration access closed |

## Verification
The timing of each result is fixed and is checked in the cycle it is due:
- Busy rises one cycle after the accepting edge.
- A dropped operation lowers busy one cycle later.
- A completed operation lowers busy PROG_LAT or ERASE_LAT cycles after that, and its flag rises at the same edge as busy falls.
- Read data and bus errors appear exactly one cycle after acceptance.

The bench drives on falling edges and counts the falling edges during which busy is high. It compares that count with the latency given by the requirement and samples the flags on the falling edge where busy is first seen low. Read results are queued when the read is issued and taken off the queue only when valid read data is seen, so stalled reads are compared whenever they actually complete.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_STAT = 2'd2,
        SEL_MASK = 2'd3
    } cfg_sel_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    localparam int CB_PG   = 0;
    localparam int CB_PER  = 1;
    localparam int CB_MER  = 2;
    localparam int CB_STRT = 6;
    localparam int CB_LOCK = 7;

    localparam int SB_PGERR = 2;
    localparam int SB_WPERR = 4;
    localparam int SB_EOP   = 5;

    localparam logic [15:0] ERASED = 16'hFFFF;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_PAGE  = 2'd1,
        OP_MASS  = 2'd2
    } op_kind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CHECK = 2'd1,
        S_WORK  = 2'd2
    } eng_state_e;

    typedef struct packed {
        op_kind_e    kind;
        logic [15:0] idx;
        logic [15:0] data;
    } op_t;

    typedef struct packed {
        logic set_eop;
        logic set_pgerr;
        logic set_wperr;
    } flags_t;

    function automatic logic [15:0] info_init(input int unsigned k);
        return 16'hC000 | 16'(k);
    endfunction

endpackage

// File: rtl/flash_cfg_regs.sv
module flash_cfg_regs
    import flash_seq_pkg::*;
#(
    parameter int PAGES = 8,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             unlock_i,
    input  logic             cfg_we_i,
    input  logic [1:0]       cfg_sel_i,
    input  logic [31:0]      cfg_wdata_i,
    input  logic             busy_i,
    input  flags_t           flags_i,
    output logic             pg_o,
    output logic             locked_o,
    output logic             strt_page_o,
    output logic             strt_mass_o,
    output logic [AW-1:0]    addr_o,
    output logic [PAGES-1:0] mask_o,
    output logic             eop_o,
    output logic             pgerr_o,
    output logic             wperr_o
);
    logic     locked_q, pg_q, eop_q, pgerr_q, wperr_q;
    logic [AW-1:0]    addr_q;
    logic [PAGES-1:0] mask_q;
    cfg_sel_e sel;
    logic     wr_ok, open_wr, ctl_wr, stat_wr, go;

    assign sel     = cfg_sel_e'(cfg_sel_i);
    assign wr_ok   = cfg_we_i && !busy_i;
    assign open_wr = wr_ok && !locked_q;
    assign ctl_wr  = open_wr && (sel == SEL_CTRL);
    assign stat_wr = wr_ok && (sel == SEL_STAT);
    assign go      = ctl_wr && cfg_wdata_i[CB_STRT] && !cfg_wdata_i[CB_LOCK];

    assign strt_mass_o = go && cfg_wdata_i[CB_MER];
    assign strt_page_o = go && cfg_wdata_i[CB_PER] && !cfg_wdata_i[CB_MER];

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b1;
            pg_q     <= 1'b0;
            addr_q   <= '0;
            mask_q   <= '0;
        end else begin
            if (unlock_i) begin
                locked_q <= 1'b0;
            end else if (ctl_wr && cfg_wdata_i[CB_LOCK]) begin
                locked_q <= 1'b1;
            end
            if (ctl_wr) begin
                pg_q <= cfg_wdata_i[CB_PG] && !cfg_wdata_i[CB_LOCK];
            end
            if (open_wr && sel == SEL_ADDR) begin
                addr_q <= cfg_wdata_i[AW-1:0];
            end
            if (open_wr && sel == SEL_MASK) begin
                mask_q <= cfg_wdata_i[PAGES-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eop_q   <= 1'b0;
            pgerr_q <= 1'b0;
            wperr_q <= 1'b0;
        end else begin
            if (flags_i.set_eop) begin
                eop_q <= 1'b1;
            end else if (stat_wr && cfg_wdata_i[SB_EOP]) begin
                eop_q <= 1'b0;
            end
            if (flags_i.set_pgerr) begin
                pgerr_q <= 1'b1;
            end else if (stat_wr && cfg_wdata_i[SB_PGERR]) begin
                pgerr_q <= 1'b0;
            end
            if (flags_i.set_wperr) begin
                wperr_q <= 1'b1;
            end else if (stat_wr && cfg_wdata_i[SB_WPERR]) begin
                wperr_q <= 1'b0;
            end
        end
    end

    assign pg_o     = pg_q;
    assign locked_o = locked_q;
    assign addr_o   = addr_q;
    assign mask_o   = mask_q;
    assign eop_o    = eop_q;
    assign pgerr_o  = pgerr_q;
    assign wperr_o  = wperr_q;

endmodule

// File: rtl/flash_store.sv
module flash_store
    import flash_seq_pkg::*;
#(
    parameter int PAGE_WORDS = 16,
    parameter int PAGES      = 8,
    parameter int INFO_WORDS = 8,
    parameter int AW         = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_idx_i,
    output logic [15:0]   rd_data_o,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_idx_i,
    input  logic [15:0]   wr_data_i,
    input  logic          page_er_i,
    input  logic [AW-1:0] page_sel_i,
    input  logic          mass_er_i
);
    localparam int USER  = PAGES * PAGE_WORDS;
    localparam int TOTAL = USER + INFO_WORDS;
    localparam logic [AW:0] TOTAL_A = (AW+1)'(TOTAL);

    logic [15:0] cells [TOTAL];

    for (genvar g = 0; g < TOTAL; g++) begin : g_cell
        logic [15:0] q;
        if (g < USER) begin : g_user
            localparam logic [AW-1:0] GI = AW'(g);
            localparam logic [AW-1:0] GP = AW'(g / PAGE_WORDS);
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= ERASED;
                end else if (mass_er_i || (page_er_i && page_sel_i == GP)) begin
                    q <= ERASED;
                end else if (wr_en_i && wr_idx_i == GI) begin
                    q <= wr_data_i;
                end
            end
        end else begin : g_info
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= info_init(g - USER);
                end
            end
        end
        assign cells[g] = q;
    end

    assign rd_data_o = ({1'b0, rd_idx_i} < TOTAL_A) ? cells[rd_idx_i] : ERASED;

endmodule

// File: rtl/flash_engine.sv
module flash_engine
    import flash_seq_pkg::*;
#(
    parameter int PAGE_WORDS = 16,
    parameter int PAGES      = 8,
    parameter int AW         = 8,
    parameter int PROG_LAT   = 4,
    parameter int ERASE_LAT  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pg_i,
    input  logic             locked_i,
    input  logic             strt_page_i,
    input  logic             strt_mass_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [PAGES-1:0] mask_i,
    input  logic             bus_req_i,
    input  logic             bus_we_i,
    input  logic [1:0]       bus_size_i,
    input  logic [AW-1:0]    bus_idx_i,
    input  logic [15:0]      bus_wdata_i,
    input  logic [15:0]      cur_data_i,
    output logic             busy_o,
    output logic             ready_o,
    output logic             bus_err_o,
    output logic [AW-1:0]    op_idx_o,
    output logic             wr_en_o,
    output logic [15:0]      wr_data_o,
    output logic             page_er_o,
    output logic [AW-1:0]    page_sel_o,
    output logic             mass_er_o,
    output flags_t           flags_o
);
    localparam int USER   = PAGES * PAGE_WORDS;
    localparam int PWB    = $clog2(PAGE_WORDS);
    localparam int PGW    = $clog2(PAGES);
    localparam int MAXLAT = (PROG_LAT > ERASE_LAT) ? PROG_LAT : ERASE_LAT;
    localparam int CW     = $clog2(MAXLAT + 1);
    localparam logic [AW:0]   USER_A  = (AW+1)'(USER);
    localparam logic [CW-1:0] PROG_C  = CW'(PROG_LAT - 1);
    localparam logic [CW-1:0] ERASE_C = CW'(ERASE_LAT - 1);

    eng_state_e    st_q;
    op_t           op_q;
    logic [CW-1:0] cnt_q;
    logic          err_q;

    logic          bus_wr, in_user_bus, prog_go, bad_wr;
    logic [AW-1:0] op_idx, op_page;
    logic          in_user_op, prot, erased_ok, finish;

    assign ready_o     = (st_q == S_IDLE) && !strt_page_i && !strt_mass_i;
    assign bus_wr      = bus_req_i && bus_we_i && ready_o;
    assign in_user_bus = {1'b0, bus_idx_i} < USER_A;
    assign prog_go     = bus_wr && pg_i && !locked_i && (bus_size_i == SZ_HALF) && in_user_bus;
    assign bad_wr      = bus_wr && !prog_go;

    assign op_idx     = op_q.idx[AW-1:0];
    assign op_page    = op_idx >> PWB;
    assign in_user_op = {1'b0, op_idx} < USER_A;
    assign prot       = !in_user_op || mask_i[op_page[PGW-1:0]];
    assign erased_ok  = (cur_data_i == ERASED) || (op_q.data == 16'h0000);
    assign finish     = (st_q == S_WORK) && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            op_q  <= '0;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= bad_wr;
            unique case (st_q)
                S_IDLE: begin
                    if (strt_mass_i) begin
                        op_q <= '{kind: OP_MASS, idx: 16'(addr_i), data: 16'h0000};
                        st_q <= S_CHECK;
                    end else if (strt_page_i) begin
                        op_q <= '{kind: OP_PAGE, idx: 16'(addr_i), data: 16'h0000};
                        st_q <= S_CHECK;
                    end else if (prog_go) begin
                        op_q <= '{kind: OP_PROG, idx: 16'(bus_idx_i), data: bus_wdata_i};
                        st_q <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    if ((op_q.kind != OP_MASS && prot) ||
                        (op_q.kind == OP_PROG && !erased_ok)) begin
                        st_q <= S_IDLE;
                    end else begin
                        st_q  <= S_WORK;
                        cnt_q <= (op_q.kind == OP_PROG) ? PROG_C : ERASE_C;
                    end
                end
                S_WORK: begin
                    if (cnt_q == '0) begin
                        st_q <= S_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        flags_o           = '0;
        flags_o.set_wperr = (st_q == S_CHECK) && (op_q.kind != OP_MASS) && prot;
        flags_o.set_pgerr = (st_q == S_CHECK) && (op_q.kind == OP_PROG) && !prot && !erased_ok;
        flags_o.set_eop   = finish;
    end

    assign busy_o     = (st_q != S_IDLE);
    assign bus_err_o  = err_q;
    assign op_idx_o   = op_idx;
    assign wr_en_o    = finish && (op_q.kind == OP_PROG);
    assign wr_data_o  = op_q.data;
    assign page_er_o  = finish && (op_q.kind == OP_PAGE);
    assign page_sel_o = op_page;
    assign mass_er_o  = finish && (op_q.kind == OP_MASS);

endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
    import flash_seq_pkg::*;
#(
    parameter int PAGE_WORDS = 16,
    parameter int PAGES      = 8,
    parameter int INFO_WORDS = 8,
    parameter int PROG_LAT   = 4,
    parameter int ERASE_LAT  = 12,
    localparam int AW        = $clog2(PAGES * PAGE_WORDS + INFO_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          unlock_i,
    input  logic          cfg_we_i,
    input  logic [1:0]    cfg_sel_i,
    input  logic [31:0]   cfg_wdata_i,
    input  logic          arr_req_i,
    input  logic          arr_we_i,
    input  logic [1:0]    arr_size_i,
    input  logic [AW-1:0] arr_idx_i,
    input  logic [15:0]   arr_wdata_i,
    output logic          arr_ready_o,
    output logic          arr_rvalid_o,
    output logic [15:0]   arr_rdata_o,
    output logic          bus_err_o,
    output logic          busy_o,
    output logic          eop_o,
    output logic          pgerr_o,
    output logic          wrprterr_o,
    output logic          locked_o
);
    logic             pg, locked, strt_page, strt_mass, busy, ready;
    logic [AW-1:0]    addr, op_idx, rd_idx, page_sel;
    logic [PAGES-1:0] mask;
    flags_t           flags;
    logic             wr_en, page_er, mass_er;
    logic [15:0]      wr_data, cell_data;
    logic             rd_go, rvalid_q;
    logic [15:0]      rdata_q;

    flash_cfg_regs #(.PAGES(PAGES), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .unlock_i(unlock_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
        .busy_i(busy), .flags_i(flags),
        .pg_o(pg), .locked_o(locked), .strt_page_o(strt_page), .strt_mass_o(strt_mass),
        .addr_o(addr), .mask_o(mask),
        .eop_o(eop_o), .pgerr_o(pgerr_o), .wperr_o(wrprterr_o)
    );

    flash_engine #(
        .PAGE_WORDS(PAGE_WORDS), .PAGES(PAGES), .AW(AW),
        .PROG_LAT(PROG_LAT), .ERASE_LAT(ERASE_LAT)
    ) u_eng (
        .clk(clk), .rst(rst), .pg_i(pg), .locked_i(locked),
        .strt_page_i(strt_page), .strt_mass_i(strt_mass),
        .addr_i(addr), .mask_i(mask),
        .bus_req_i(arr_req_i), .bus_we_i(arr_we_i), .bus_size_i(arr_size_i),
        .bus_idx_i(arr_idx_i), .bus_wdata_i(arr_wdata_i),
        .cur_data_i(cell_data),
        .busy_o(busy), .ready_o(ready), .bus_err_o(bus_err_o),
        .op_idx_o(op_idx), .wr_en_o(wr_en), .wr_data_o(wr_data),
        .page_er_o(page_er), .page_sel_o(page_sel), .mass_er_o(mass_er),
        .flags_o(flags)
    );

    assign rd_idx = busy ? op_idx : arr_idx_i;

    flash_store #(
        .PAGE_WORDS(PAGE_WORDS), .PAGES(PAGES), .INFO_WORDS(INFO_WORDS), .AW(AW)
    ) u_store (
        .clk(clk), .rst(rst),
        .rd_idx_i(rd_idx), .rd_data_o(cell_data),
        .wr_en_i(wr_en), .wr_idx_i(op_idx), .wr_data_i(wr_data),
        .page_er_i(page_er), .page_sel_i(page_sel), .mass_er_i(mass_er)
    );

    assign rd_go = arr_req_i && !arr_we_i && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= rd_go;
            if (rd_go) begin
                rdata_q <= cell_data;
            end
        end
    end

    assign arr_ready_o  = ready;
    assign arr_rvalid_o = rvalid_q;
    assign arr_rdata_o  = rdata_q;
    assign busy_o       = busy;
    assign locked_o     = locked;

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       unlock_i,
    input logic       cfg_we_i,
    input logic [1:0] cfg_sel_i,
    input logic       arr_req_i,
    input logic       arr_we_i,
    input logic       arr_ready_o,
    input logic       arr_rvalid_o,
    input logic       bus_err_o,
    input logic       busy_o,
    input logic       eop_o,
    input logic       pgerr_o,
    input logic       wrprterr_o,
    input logic       locked_o
);
    // R10
    busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !arr_ready_o);

    // R2
    eop_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(eop_o) |-> $fell(busy_o));

    // R4
    pgerr_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pgerr_o) |-> $fell(busy_o));

    // R6
    wperr_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wrprterr_o) |-> $fell(busy_o));

    // R3
    bus_err_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err_o |-> (!busy_o && $past(arr_req_i && arr_we_i && arr_ready_o)));

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |->
            $past((arr_req_i && arr_we_i && arr_ready_o) || (cfg_we_i && cfg_sel_i == 2'd0)));

    // R11
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (locked_o && !unlock_i) |=> locked_o);

    // R10
    rvalid_src_chk: assert property (@(posedge clk) disable iff (rst)
        arr_rvalid_o |-> $past(arr_req_i && !arr_we_i && arr_ready_o));

endmodule

bind flash_seq_top flash_seq_chk u_chk (
    .clk(clk), .rst(rst), .unlock_i(unlock_i),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .arr_req_i(arr_req_i), .arr_we_i(arr_we_i), .arr_ready_o(arr_ready_o),
    .arr_rvalid_o(arr_rvalid_o), .bus_err_o(bus_err_o), .busy_o(busy_o),
    .eop_o(eop_o), .pgerr_o(pgerr_o), .wrprterr_o(wrprterr_o), .locked_o(locked_o)
);

// File: tb/sim_flash_seq_top.sv
`timescale 1ns/1ps
module sim_flash_seq_top;
    localparam int PL   = 4;
    localparam int EL   = 12;
    localparam int INFO = 128;
    localparam logic [31:0] C_PG = 32'h01, C_PER = 32'h02, C_MER = 32'h04,
                            C_STRT = 32'h40, C_LOCK = 32'h80;
    localparam logic [31:0] S_PGERR = 32'h04, S_WPERR = 32'h10, S_EOP = 32'h20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        unlock_i = 1'b0, cfg_we_i = 1'b0;
    logic [1:0]  cfg_sel_i = '0;
    logic [31:0] cfg_wdata_i = '0;
    logic        arr_req_i = 1'b0, arr_we_i = 1'b0;
    logic [1:0]  arr_size_i = 2'b01;
    logic [7:0]  arr_idx_i = '0;
    logic [15:0] arr_wdata_i = '0;
    logic        arr_ready_o, arr_rvalid_o, bus_err_o, busy_o;
    logic        eop_o, pgerr_o, wrprterr_o, locked_o;
    logic [15:0] arr_rdata_o;

    always #4 clk = ~clk;

    flash_seq_top u0 (
        .clk(clk), .rst(rst), .unlock_i(unlock_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
        .arr_req_i(arr_req_i), .arr_we_i(arr_we_i), .arr_size_i(arr_size_i),
        .arr_idx_i(arr_idx_i), .arr_wdata_i(arr_wdata_i),
        .arr_ready_o(arr_ready_o), .arr_rvalid_o(arr_rvalid_o), .arr_rdata_o(arr_rdata_o),
        .bus_err_o(bus_err_o), .busy_o(busy_o), .eop_o(eop_o), .pgerr_o(pgerr_o),
        .wrprterr_o(wrprterr_o), .locked_o(locked_o)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {int req; logic [15:0] val;} exp_t;
    exp_t exp_q[$];

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: pop the expected read result when read data appears
    always @(negedge clk) begin
        if (!rst && arr_rvalid_o) begin
            exp_t e;
            if (exp_q.size() == 0) begin
                check(10, "unexpected read data", 32'(arr_rdata_o), 32'hDEAD);
            end else begin
                e = exp_q.pop_front();
                check(e.req, "read data", 32'(arr_rdata_o), 32'(e.val));
            end
        end
    end

    task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] d);
        cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic arr_acc(input logic we, input logic [1:0] sz,
                           input logic [7:0] idx, input logic [15:0] d);
        logic ok;
        arr_req_i = 1'b1; arr_we_i = we; arr_size_i = sz;
        arr_idx_i = idx; arr_wdata_i = d;
        forever begin
            #1 ok = arr_ready_o;
            @(negedge clk);
            if (ok) break;
        end
        arr_req_i = 1'b0; arr_we_i = 1'b0;
    endtask

    // Driver: push the expected read result, then issue the read
    task automatic rd(input logic [7:0] idx, input logic [15:0] exp, input int req);
        exp_q.push_back('{req, exp});
        arr_acc(1'b0, 2'b01, idx, 16'h0);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy_o) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_unlock();
        unlock_i = 1'b1;
        @(negedge clk);
        unlock_i = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(1, "busy", 32'(busy_o), 0);
        check(1, "eop", 32'(eop_o), 0);
        check(1, "pgerr", 32'(pgerr_o), 0);
        check(1, "wperr", 32'(wrprterr_o), 0);
        check(1, "locked", 32'(locked_o), 1);
        rd(8'd5, 16'hFFFF, 1);
        rd(8'(INFO + 2), 16'hC002, 1);

        // R11 locked: program-enable write ignored, so the write is rejected
        cfg_wr(2'd0, C_PG);
        arr_acc(1'b1, 2'b01, 8'd3, 16'h1234);
        check(11, "bus_err while locked", 32'(bus_err_o), 1);
        check(11, "no op while locked", 32'(busy_o), 0);
        pulse_unlock();
        check(11, "unlocked", 32'(locked_o), 0);

        // R3 wrong size and program-enable clear
        cfg_wr(2'd0, C_PG);
        arr_acc(1'b1, 2'b00, 8'd3, 16'h1234);
        check(3, "bus_err byte", 32'(bus_err_o), 1);
        check(3, "busy after byte", 32'(busy_o), 0);
        arr_acc(1'b1, 2'b10, 8'd3, 16'h1234);
        check(3, "bus_err word", 32'(bus_err_o), 1);
        rd(8'd3, 16'hFFFF, 3);

        // R2 program
        arr_acc(1'b1, 2'b01, 8'd3, 16'h1234);
        busy_len(n);
        check(2, "program busy cycles", 32'(n), PL + 1);
        check(2, "eop", 32'(eop_o), 1);
        check(2, "pgerr", 32'(pgerr_o), 0);
        rd(8'd3, 16'h1234, 2);

        // R9 write-one-to-clear
        cfg_wr(2'd2, 32'h0);
        check(9, "eop kept on zero write", 32'(eop_o), 1);
        cfg_wr(2'd2, S_EOP);
        check(9, "eop cleared", 32'(eop_o), 0);

        // R4 program onto a written cell
        arr_acc(1'b1, 2'b01, 8'd3, 16'h5555);
        busy_len(n);
        check(4, "dropped busy cycles", 32'(n), 1);
        check(4, "pgerr", 32'(pgerr_o), 1);
        check(4, "eop", 32'(eop_o), 0);
        rd(8'd3, 16'h1234, 4);
        cfg_wr(2'd2, S_PGERR);
        check(9, "pgerr cleared", 32'(pgerr_o), 0);

        // R5 zero write
        arr_acc(1'b1, 2'b01, 8'd3, 16'h0000);
        busy_len(n);
        check(5, "zero write busy cycles", 32'(n), PL + 1);
        check(5, "eop", 32'(eop_o), 1);
        check(5, "pgerr", 32'(pgerr_o), 0);
        rd(8'd3, 16'h0000, 5);
        cfg_wr(2'd2, S_EOP);

        // Fill page 1 and page 2 cells
        arr_acc(1'b1, 2'b01, 8'd20, 16'h2222);
        busy_len(n);
        arr_acc(1'b1, 2'b01, 8'd33, 16'hABCD);
        busy_len(n);
        arr_acc(1'b1, 2'b01, 8'd40, 16'h1111);
        busy_len(n);
        cfg_wr(2'd2, S_EOP);

        // R6 protected page
        cfg_wr(2'd3, 32'h2);
        arr_acc(1'b1, 2'b01, 8'd21, 16'h7777);
        busy_len(n);
        check(6, "protected busy cycles", 32'(n), 1);
        check(6, "wperr", 32'(wrprterr_o), 1);
        check(6, "eop", 32'(eop_o), 0);
        rd(8'd21, 16'hFFFF, 6);
        cfg_wr(2'd2, S_WPERR);
        check(9, "wperr cleared", 32'(wrprterr_o), 0);
        cfg_wr(2'd1, 32'd16);
        cfg_wr(2'd0, C_PER | C_STRT);
        busy_len(n);
        check(6, "protected erase busy cycles", 32'(n), 1);
        check(6, "wperr on erase", 32'(wrprterr_o), 1);
        rd(8'd20, 16'h2222, 6);
        cfg_wr(2'd2, S_WPERR);

        // R7 page erase of page 2
        cfg_wr(2'd1, 32'd34);
        cfg_wr(2'd0, C_PER | C_STRT);
        busy_len(n);
        check(7, "page erase busy cycles", 32'(n), EL + 1);
        check(7, "eop", 32'(eop_o), 1);
        rd(8'd33, 16'hFFFF, 7);
        rd(8'd40, 16'hFFFF, 7);
        rd(8'd3, 16'h0000, 7);
        cfg_wr(2'd2, S_EOP);
        cfg_wr(2'd0, C_STRT);
        check(7, "start alone idle", 32'(busy_o), 0);

        // R10 busy: config writes ignored, reads stalled
        cfg_wr(2'd0, C_PG);
        arr_acc(1'b1, 2'b01, 8'd50, 16'h7777);
        check(10, "ready low while busy", 32'(arr_ready_o), 0);
        cfg_wr(2'd0, C_LOCK);
        rd(8'd50, 16'h7777, 10);
        check(10, "lock write ignored", 32'(locked_o), 0);
        check(10, "eop after stalled read", 32'(eop_o), 1);
        cfg_wr(2'd2, S_EOP);

        // R8 mass erase regardless of mask
        cfg_wr(2'd0, C_MER | C_STRT);
        busy_len(n);
        check(8, "mass erase busy cycles", 32'(n), EL + 1);
        check(8, "eop", 32'(eop_o), 1);
        rd(8'd3, 16'hFFFF, 8);
        rd(8'd20, 16'hFFFF, 8);
        rd(8'd50, 16'hFFFF, 8);
        rd(8'(INFO + 2), 16'hC002, 8);

        // R11 relock
        cfg_wr(2'd0, C_LOCK);
        check(11, "relocked", 32'(locked_o), 1);

        repeat (3) @(negedge clk);
        check(10, "all reads returned", 32'(exp_q.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule